// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block computes a data result and a set of six status flags for one arithmetic or bitwise operation per clock. Two operands, an operation code and an operand-size select enter the block. The result comes out combinationally in the same cycle. The flags are captured into a register on the next rising clock edge, but only when the update enable is asserted. Operands can be treated as 8, 16 or 32 bits wide. Every flag, and the result itself, is evaluated at the chosen width.

The block is meant to sit beside an execution datapath. The caller reads `result` in the same cycle it presents the operands. It reads the captured flags one cycle later, for use by conditional logic that follows. An instruction that must not disturb the flags holds the enable low. The flags word then keeps its previous value for as long as required.

Top module: `stat_flag_unit`

## Requirements
- R1: With `op_sel` = 0 (add), `result` equals (A + B) modulo 2^n, where n is the selected width. Bits of `result` at and above n are 0.
- R2: With `op_sel` = 1 (subtract), `result` equals (A − B) modulo 2^n. Bits at and above n are 0.
- R3: With `op_sel` = 2 (AND), 3 (OR) or 4 (XOR), `result` is the bitwise function of the two operands, masked to n bits. The captured carry, overflow and nibble-carry flags are 0.
- R4: With `op_sel` = 5, 6 or 7, `result` is 0. The captured carry, overflow and nibble-carry flags are 0.
- R5: `flags_q[5]` (carry) captures the unsigned carry out of bit n−1 for add. For subtract it captures a borrow, which occurs when the unsigned A is less than the unsigned B.
- R6: `flags_q[4]` (overflow) captures whether the signed two's-complement result of add or subtract falls outside the range of n bits.
- R7: `flags_q[3]` (sign) captures bit n−1 of the result.
- R8: `flags_q[2]` (zero) captures whether the n-bit result is all zeros.
- R9: `flags_q[1]` (nibble carry) captures the carry out of bit 3 for add. For subtract it captures a borrow into bit 3, which occurs when the low nibble of A is less than the low nibble of B.
- R10: `flags_q[0]` (parity) captures 1 when the count of 1 bits in `result[7:0]` is even. This holds whatever the width.
- R11: Flags are captured on the rising clock edge only when `flag_we` is 1. Otherwise `flags_q` holds its value, while `result` still follows the inputs.
- R12: While `rst_n` is low, `flags_q` is 0.
- R13: `size_sel` selects the width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, and 3 also gives 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (subtrahend for subtract) |
| op_sel | input | 3 | Operation code |
| size_sel | input | 2 | Operand width select |
| flag_we | input | 1 | Flags capture enable |
| result | output | 32 | Combinational result, zero above the selected width |
| flags_q | output | 6 | Registered flags {carry, overflow, sign, zero, nibble carry, parity} |

## Verification
Some checks are made on every cycle. The assertions confirm that the flags hold while the enable is low. They confirm that the bitwise and unused codes clear carry, overflow and nibble carry. They also confirm that sign, zero and parity match the result seen in the cycle before, and that the result is clear above a byte-wide operand. Carry, overflow and nibble carry/borrow depend on the operand values in ways no simple property can state. Those flags, and the arithmetic result, are shown only by the bench's sweeps. The bench covers every first operand against a strided set of second operands at byte width, and a set of corner operands at the wider widths. In each case it compares against values it computes arithmetically.

// File: rtl/statflag_pkg.sv
package statflag_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int PAR_W  = 8;
    localparam int FLAG_N = 6;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_RSV5 = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } size_e;

    typedef struct packed {
        logic cf;
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
    } flags_t;

    function automatic logic [DATA_W-1:0] size_mask(size_e s);
        logic [DATA_W-1:0] m;
        unique case (s)
            SZ_BYTE: m = DATA_W'({BYTE_W{1'b1}});
            SZ_HALF: m = DATA_W'({HALF_W{1'b1}});
            default: m = {DATA_W{1'b1}};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/stat_arith.sv
module stat_arith
    import statflag_pkg::*;
(
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              sub_en,
    input  size_e             size,
    output logic [DATA_W-1:0] sum_out,
    output logic              carry_o,
    output logic              ovf_o,
    output logic              nib_o
);

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] a_m;
    logic [DATA_W-1:0] b_x;
    logic [DATA_W:0]   full;
    logic [NIB_W:0]    nib;
    logic              carry_raw;
    logic              a_s;
    logic              b_s;
    logic              r_s;

    always_comb begin
        mask = size_mask(size);
        a_m  = a_in & mask;
        b_x  = (b_in ^ {DATA_W{sub_en}}) & mask;
        full = {1'b0, a_m} + {1'b0, b_x} + (DATA_W+1)'(sub_en);
        nib  = {1'b0, a_m[NIB_W-1:0]} + {1'b0, b_x[NIB_W-1:0]} + (NIB_W+1)'(sub_en);
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                carry_raw = full[BYTE_W];
                a_s       = a_m[BYTE_W-1];
                b_s       = b_x[BYTE_W-1];
                r_s       = full[BYTE_W-1];
            end
            SZ_HALF: begin
                carry_raw = full[HALF_W];
                a_s       = a_m[HALF_W-1];
                b_s       = b_x[HALF_W-1];
                r_s       = full[HALF_W-1];
            end
            default: begin
                carry_raw = full[DATA_W];
                a_s       = a_m[DATA_W-1];
                b_s       = b_x[DATA_W-1];
                r_s       = full[DATA_W-1];
            end
        endcase
    end

    assign sum_out = full[DATA_W-1:0] & mask;
    assign carry_o = carry_raw ^ sub_en;
    assign nib_o   = nib[NIB_W] ^ sub_en;
    assign ovf_o   = (a_s == b_s) && (r_s != a_s);

endmodule

// File: rtl/stat_logic.sv
module stat_logic
    import statflag_pkg::*;
(
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  op_e               op,
    input  size_e             size,
    output logic [DATA_W-1:0] res_out
);

    logic [DATA_W-1:0] raw;

    always_comb begin
        case (op)
            OP_AND:  raw = a_in & b_in;
            OP_OR:   raw = a_in | b_in;
            OP_XOR:  raw = a_in ^ b_in;
            default: raw = '0;
        endcase
    end

    assign res_out = raw & size_mask(size);

endmodule

// File: rtl/stat_flags_calc.sv
module stat_flags_calc
    import statflag_pkg::*;
(
    input  logic [DATA_W-1:0] res,
    input  size_e             size,
    input  logic              arith_en,
    input  logic              carry_i,
    input  logic              ovf_i,
    input  logic              nib_i,
    output flags_t            flags_d
);

    logic msb;

    always_comb begin
        unique case (size)
            SZ_BYTE: msb = res[BYTE_W-1];
            SZ_HALF: msb = res[HALF_W-1];
            default: msb = res[DATA_W-1];
        endcase
    end

    always_comb begin
        flags_d.cf = arith_en & carry_i;
        flags_d.of = arith_en & ovf_i;
        flags_d.af = arith_en & nib_i;
        flags_d.sf = msb;
        flags_d.zf = (res == '0);
        flags_d.pf = ~^res[PAR_W-1:0];
    end

endmodule

// File: rtl/stat_flag_unit.sv
module stat_flag_unit
    import statflag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       opnd_a,
    input  logic [31:0]       opnd_b,
    input  logic [2:0]        op_sel,
    input  logic [1:0]        size_sel,
    input  logic              flag_we,
    output logic [31:0]       result,
    output logic [5:0]        flags_q
);

    op_e               op;
    size_e             size;
    logic              arith_en;
    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] log_w;
    logic              carry_w;
    logic              ovf_w;
    logic              nib_w;
    flags_t            flags_d;
    flags_t            flags_r;

    assign op       = op_e'(op_sel);
    assign size     = size_e'(size_sel);
    assign arith_en = (op == OP_ADD) || (op == OP_SUB);

    stat_arith u_arith (
        .a_in    (opnd_a),
        .b_in    (opnd_b),
        .sub_en  (op == OP_SUB),
        .size    (size),
        .sum_out (sum_w),
        .carry_o (carry_w),
        .ovf_o   (ovf_w),
        .nib_o   (nib_w)
    );

    stat_logic u_logic (
        .a_in    (opnd_a),
        .b_in    (opnd_b),
        .op      (op),
        .size    (size),
        .res_out (log_w)
    );

    assign result = arith_en ? sum_w : log_w;

    stat_flags_calc u_flags (
        .res      (result),
        .size     (size),
        .arith_en (arith_en),
        .carry_i  (carry_w),
        .ovf_i    (ovf_w),
        .nib_i    (nib_w),
        .flags_d  (flags_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_r <= '0;
        end else if (flag_we) begin
            flags_r <= flags_d;
        end
    end

    assign flags_q = flags_r;

endmodule

// File: rtl/stat_flag_unit_chk.sv
module stat_flag_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  op_sel,
    input logic [1:0]  size_sel,
    input logic        flag_we,
    input logic [31:0] result,
    input logic [5:0]  flags_q
);

    // R11: flags hold while capture is disabled
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags_q));

    // R3 and R4: bitwise and unused codes clear carry, overflow, nibble carry
    p_logic_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && (op_sel > 3'd1)) |=> (flags_q[5] == 1'b0 && flags_q[4] == 1'b0 && flags_q[1] == 1'b0));

    // R8: zero flag tracks the previous result
    p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flags_q[2] == ($past(result) == 32'd0)));

    // R10: parity over the low byte of the previous result
    p_parity_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flags_q[0] == ($countones($past(result[7:0])) % 2 == 0)));

    // R7: sign flag is the top bit at the selected width
    p_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flags_q[3] == (($past(size_sel) == 2'd0) ? $past(result[7]) :
                                    ($past(size_sel) == 2'd1) ? $past(result[15]) :
                                                                $past(result[31]))));

    // R1: byte width leaves upper result bits clear
    p_upper_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (size_sel == 2'd0) |-> (result[31:8] == 24'd0));

endmodule

bind stat_flag_unit stat_flag_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_sel   (op_sel),
    .size_sel (size_sel),
    .flag_we  (flag_we),
    .result   (result),
    .flags_q  (flags_q)
);

// File: tb/test_stat_flag_unit.sv
module test_stat_flag_unit;

    logic        clk;
    logic        rst_n;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [2:0]  op_sel;
    logic [1:0]  size_sel;
    logic        flag_we;
    logic [31:0] result;
    logic [5:0]  flags_q;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    stat_flag_unit i_stat_flag_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .op_sel   (op_sel),
        .size_sel (size_sel),
        .flag_we  (flag_we),
        .result   (result),
        .flags_q  (flags_q)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Arithmetic reference model. Flags packed {cf,of,sf,zf,af,pf}.
    task automatic model(input int op, input int sz, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] res, output logic [5:0] fl);
        int     n;
        longint mask, am, bm, sa, sb, s, t, lo, hi;
        bit     cf, of, af;
        n    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        mask = (64'd1 << n) - 1;
        am   = longint'(a) & mask;
        bm   = longint'(b) & mask;
        sa   = (am >= (64'd1 << (n-1))) ? am - (64'd1 << n) : am;
        sb   = (bm >= (64'd1 << (n-1))) ? bm - (64'd1 << n) : bm;
        hi   = (64'd1 << (n-1)) - 1;
        lo   = -(64'd1 << (n-1));
        cf = 0; of = 0; af = 0;
        case (op)
            0: begin
                s  = am + bm;
                cf = (s > mask);
                t  = sa + sb;
                of = (t > hi) || (t < lo);
                af = ((am & 15) + (bm & 15)) > 15;
            end
            1: begin
                s  = am - bm;
                cf = (am < bm);
                t  = sa - sb;
                of = (t > hi) || (t < lo);
                af = ((am & 15) < (bm & 15));
            end
            2: s = am & bm;
            3: s = am | bm;
            4: s = am ^ bm;
            default: s = 0;
        endcase
        res   = 32'(s & mask);
        fl[5] = cf;
        fl[4] = of;
        fl[3] = res[n-1];
        fl[2] = (res == 32'd0);
        fl[1] = af;
        fl[0] = ($countones(res[7:0]) % 2 == 0);
    endtask

    task automatic run_vec(input int op, input int sz, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er;
        logic [5:0]  ef;
        string       rtag;
        @(negedge clk);
        op_sel   = 3'(op);
        size_sel = 2'(sz);
        opnd_a   = a;
        opnd_b   = b;
        flag_we  = 1'b1;
        model(op, sz, a, b, er, ef);
        rtag = (op == 0) ? "R1 add" : (op == 1) ? "R2 sub" : (op <= 4) ? "R3 logic" : "R4 unused op";
        if (sz == 3) rtag = {rtag, " R13 size3"};
        #1;
        check(result == er, rtag, result, er);
        @(posedge clk);
        #1;
        check(flags_q[5] == ef[5], "R5 carry",    flags_q[5], ef[5]);
        check(flags_q[4] == ef[4], "R6 overflow", flags_q[4], ef[4]);
        check(flags_q[3] == ef[3], "R7 sign",     flags_q[3], ef[3]);
        check(flags_q[2] == ef[2], "R8 zero",     flags_q[2], ef[2]);
        check(flags_q[1] == ef[1], "R9 nibble",   flags_q[1], ef[1]);
        check(flags_q[0] == ef[0], "R10 parity",  flags_q[0], ef[0]);
    endtask

    logic [31:0] corners [17];

    initial begin
        corners = '{32'h0, 32'h1, 32'h7, 32'h8, 32'hF, 32'h10, 32'h7F, 32'h80, 32'hFF,
                    32'h7FFF, 32'h8000, 32'hFFFF, 32'h7FFFFFFF, 32'h80000000,
                    32'hFFFFFFFF, 32'h12345678, 32'hDEADBEEF};
        rst_n = 1'b0; opnd_a = '0; opnd_b = '0; op_sel = '0; size_sel = '0; flag_we = 1'b1;
        opnd_a = 32'hFF; opnd_b = 32'h1;
        repeat (3) @(posedge clk);
        #1;
        check(flags_q == 6'd0, "R12 reset", flags_q, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // byte width, arithmetic: all A against strided B
        for (int op = 0; op < 2; op++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b += 3)
                    run_vec(op, 0, 32'(a), 32'(b));

        // byte width, bitwise and unused codes
        for (int op = 2; op < 8; op++)
            for (int a = 0; a < 256; a += 5)
                for (int b = 0; b < 256; b += 7)
                    run_vec(op, 0, 32'(a) | 32'hABCD_0000, 32'(b) | 32'h5500_0000);

        // corner operands at every width code
        for (int op = 0; op < 6; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int i = 0; i < 17; i++)
                    for (int j = 0; j < 17; j++)
                        run_vec(op, sz, corners[i], corners[j]);

        // R11: hold with capture disabled
        run_vec(0, 0, 32'hFF, 32'h01);   // carry, zero, nibble set
        @(negedge clk);
        op_sel = 3'd0; size_sel = 2'd0; opnd_a = 32'h40; opnd_b = 32'h40; flag_we = 1'b0;
        #1;
        check(result == 32'h80, "R11 result still live", result, 32'h80);
        @(posedge clk);
        #1;
        check(flags_q == 6'b100111, "R11 hold", flags_q, 6'b100111);
        @(negedge clk);
        flag_we = 1'b1;
        @(posedge clk);
        #1;
        check(flags_q == 6'b011000, "R11 capture after hold", flags_q, 6'b011000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule